// File: doc/BRIEF.md
# SPI Master/Slave Byte Controller

This block moves one byte at a time over a four-wire serial peripheral link. It is set up through a single 8-bit configuration register. The register turns the block on or off, picks the bit order, chooses the master or slave role, sets the clock idle level and the sampling phase, and selects one of eight master clock rates. In the master role, a write to the transmit port starts a transfer. The block makes SCK from the system clock, shifts the byte out on MOSI, and captures MISO as it goes.

In the slave role, the block follows an SCK and an active-low select driven from outside. Both are brought into the system clock domain by a short synchronizer chain, and their edges are detected there. Data enters on MOSI and leaves on MISO. When a byte completes in either role, the received byte is latched on the receive port and a done flag goes high. The flag stays high until a new transmit byte is accepted.

Top module: `spi_ctl_top`

## Requirements
- R1: The configuration register is 8 bits wide, resets to 0x00 and reads back what was written. Bit 7 is enable, bit 6 is LSB-first, bit 5 is master, bit 4 is CPOL, bit 3 is CPHA, bit 2 is the double-rate bit, and bits 1:0 are the rate code.
- R2: While enable is 0, a transmit write starts no transfer, SCK does not toggle, and the done flag stays 0.
- R3: With enable=1 and master=1, a transmit write starts an 8-bit transfer of exactly 16 SCK edges. SCK rests at the CPOL level before and after the transfer.
- R4: The master SCK period, in system clocks, is set by the code {double, rate1, rate0}: 000=4, 001=16, 010=64, 011=128, 100=2, 101=8, 110=32, 111=64.
- R5: With CPHA=0, data is sampled on the leading SCK edge and changed on the trailing edge. With CPHA=1, it is changed on the leading edge and sampled on the trailing edge. The leading edge is the one leaving the CPOL level.
- R6: LSB-first=0 sends and receives bit 7 first. LSB-first=1 sends and receives bit 0 first.
- R7: With CPHA=0, the first data bit is already on the output line before the first SCK edge. In the master role it is placed there when the transfer starts. In the slave role it is placed there when select goes low.
- R8: The done flag rises in the cycle of the sixteenth SCK edge, and the receive port then holds the received byte. An accepted transmit write clears the flag.
- R9: In the slave role (enable=1, master=0), the block shifts the loaded transmit byte out on MISO and receives MOSI, following the external SCK and select in all four CPOL/CPHA modes.
- R10: If select rises in the middle of a byte, the partial transfer is dropped and the edge count goes back to zero. No done is raised, and the next full byte is received correctly.
- R11: A transmit write during an active master transfer is ignored, and the byte already being shifted is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration register contents |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_rdata | output | 8 | Last received byte |
| xfer_done | output | 1 | Byte complete flag |
| sck_o | output | 1 | Serial clock driven in the master role |
| sck_i | input | 1 | Serial clock received in the slave role |
| ss_n_i | input | 1 | Active-low select received in the slave role |
| mosi_o | output | 1 | Serial data out in the master role |
| mosi_i | input | 1 | Serial data in in the slave role |
| miso_o | output | 1 | Serial data out in the slave role |
| miso_i | input | 1 | Serial data in in the master role |

## Verification
The bench runs a master transfer for all 64 combinations of clock mode, bit order and rate code. A swapped rate entry, for example treating the top code as a doubled fx/128, shows up as a wrong measured SCK period. A sample taken on the wrong edge corrupts the captured bytes. In the slave role it checks that the first bit is present before any clock edge when CPHA=0; a late first bit loses bit 0. It also checks that a select pulled high mid-byte restarts the count; a design that kept the count would frame the next byte off by some bits or raise a spurious done. A transmit write during a master transfer must not change the outgoing byte, and a disabled block must not produce any clock at all.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 7;

    typedef struct packed {
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic       dbl;
        logic [1:0] rate;
    } spi_cfg_t;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_XFER = 1'b1
    } mstate_t;

    // Half SCK period minus one, in system clocks.
    // Base log2 of the half period per rate code: 1,3,5,6; the double bit subtracts one.
    function automatic logic [DIV_W-1:0] half_period_m1(input logic dbl, input logic [1:0] rate);
        logic [2:0]       ex;
        logic [DIV_W-1:0] half;
        ex   = (rate == 2'd3) ? 3'd6 : {rate, 1'b1};
        ex   = ex - {2'b00, dbl};
        half = DIV_W'(1) << ex;
        return half - DIV_W'(1);
    endfunction

endpackage

// File: rtl/spi_ctl_clkdiv.sv
module spi_ctl_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q >= half_m1);
    assign tick = run && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Ticks are spaced by the half period; only the fastest code may tick back to back.
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && (half_m1 != '0)) |=> (!tick || (half_m1 == '0)));

endmodule

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic ss_n_in,
    input  logic sdi_in,
    output logic sdi_s,
    output logic ss_act,
    output logic sck_edge,
    output logic ss_start,
    output logic ss_end
);

    logic [STAGES-1:0] sck_pipe, ss_pipe, sdi_pipe;
    logic              sck_prev_q, ss_act_prev_q;
    logic              sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_pipe      <= '0;
            ss_pipe       <= '1;
            sdi_pipe      <= '0;
            sck_prev_q    <= 1'b0;
            ss_act_prev_q <= 1'b0;
        end else begin
            sck_pipe      <= {sck_pipe[STAGES-2:0], sck_in};
            ss_pipe       <= {ss_pipe[STAGES-2:0], ss_n_in};
            sdi_pipe      <= {sdi_pipe[STAGES-2:0], sdi_in};
            sck_prev_q    <= sck_s;
            ss_act_prev_q <= ss_act;
        end
    end

    assign sck_s    = sck_pipe[STAGES-1];
    assign sdi_s    = sdi_pipe[STAGES-1];
    assign ss_act   = !ss_pipe[STAGES-1];
    assign sck_edge = sck_s ^ sck_prev_q;
    assign ss_start = ss_act && !ss_act_prev_q;
    assign ss_end   = !ss_act && ss_act_prev_q;

endmodule

// File: rtl/spi_ctl_shifter.sv
module spi_ctl_shifter #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(2 * BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              clear,
    input  logic              edge_evt,
    input  logic              lsb_first,
    input  logic              cpha,
    input  logic              din,
    output logic              dout,
    output logic              last_edge,
    output logic [BYTE_W-1:0] rx_next,
    output logic [CNT_W-1:0]  cnt
);

    localparam int              EDGES = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    logic [BYTE_W-1:0] tx_q, rx_q, tx_shifted;
    logic [CNT_W-1:0]  cnt_q;
    logic              leading, sample_now, shift_now;

    assign leading    = !cnt_q[0];
    assign sample_now = edge_evt && (cpha ? !leading : leading);
    assign shift_now  = edge_evt && (cpha ? (leading && cnt_q != '0) : (!leading && cnt_q != LAST));
    assign last_edge  = edge_evt && (cnt_q == LAST);

    assign tx_shifted = lsb_first ? {1'b0, tx_q[BYTE_W-1:1]} : {tx_q[BYTE_W-2:0], 1'b0};
    assign rx_next    = !sample_now ? rx_q :
                        (lsb_first ? {din, rx_q[BYTE_W-1:1]} : {rx_q[BYTE_W-2:0], din});
    assign dout       = lsb_first ? tx_q[0] : tx_q[BYTE_W-1];
    assign cnt        = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            tx_q  <= load_data;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (edge_evt) begin
            cnt_q <= last_edge ? '0 : cnt_q + CNT_W'(1);
            rx_q  <= rx_next;
            if (shift_now) begin
                tx_q <= tx_shifted;
            end
        end
    end

endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
    import spi_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       tx_we,
    input  logic [7:0] tx_wdata,
    output logic [7:0] rx_rdata,
    output logic       xfer_done,
    output logic       sck_o,
    input  logic       sck_i,
    input  logic       ss_n_i,
    output logic       mosi_o,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic       miso_i
);

    localparam int CNT_W = $clog2(2 * BYTE_W);

    spi_cfg_t          cfg_q;
    mstate_t           state_q;
    logic              sck_q, done_q;
    logic [BYTE_W-1:0] rx_q, tx_hold_q, rx_next, load_data;
    logic [DIV_W-1:0]  half_m1;
    logic [CNT_W-1:0]  bit_cnt;
    logic              is_master, is_slave, start, tx_accept;
    logic              tick, m_edge, s_edge, edge_evt, din, dout, last_edge;
    logic              sdi_s, ss_act, sck_edge, ss_start, ss_end;
    logic              load, clear;

    assign is_master = cfg_q.en && cfg_q.master;
    assign is_slave  = cfg_q.en && !cfg_q.master;
    assign tx_accept = tx_we && (state_q == S_IDLE);
    assign start     = tx_accept && is_master;
    assign half_m1   = half_period_m1(cfg_q.dbl, cfg_q.rate);

    spi_ctl_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == S_XFER),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    spi_ctl_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_in   (sck_i),
        .ss_n_in  (ss_n_i),
        .sdi_in   (mosi_i),
        .sdi_s    (sdi_s),
        .ss_act   (ss_act),
        .sck_edge (sck_edge),
        .ss_start (ss_start),
        .ss_end   (ss_end)
    );

    assign m_edge    = (state_q == S_XFER) && tick;
    assign s_edge    = is_slave && ss_act && sck_edge;
    assign edge_evt  = is_master ? m_edge : s_edge;
    assign din       = is_master ? miso_i : sdi_s;
    assign load      = start || (is_slave && ss_start) || (tx_accept && is_slave && !ss_act);
    assign load_data = tx_accept ? tx_wdata : tx_hold_q;
    assign clear     = (is_slave && ss_end) || ((state_q == S_XFER) && !is_master);

    spi_ctl_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .clear     (clear),
        .edge_evt  (edge_evt),
        .lsb_first (cfg_q.lsb_first),
        .cpha      (cfg_q.cpha),
        .din       (din),
        .dout      (dout),
        .last_edge (last_edge),
        .rx_next   (rx_next),
        .cnt       (bit_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            state_q   <= S_IDLE;
            sck_q     <= 1'b0;
            done_q    <= 1'b0;
            rx_q      <= '0;
            tx_hold_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q <= spi_cfg_t'(cfg_wdata);
            end
            if (tx_accept) begin
                tx_hold_q <= tx_wdata;
            end
            unique case (state_q)
                S_IDLE: begin
                    sck_q <= cfg_q.cpol;
                    if (start) begin
                        state_q <= S_XFER;
                    end
                end
                S_XFER: begin
                    if (!is_master) begin
                        state_q <= S_IDLE;
                        sck_q   <= cfg_q.cpol;
                    end else begin
                        if (m_edge) begin
                            sck_q <= !sck_q;
                        end
                        if (last_edge) begin
                            state_q <= S_IDLE;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
            if (last_edge) begin
                done_q <= 1'b1;
                rx_q   <= rx_next;
            end else if (tx_accept) begin
                done_q <= 1'b0;
            end
        end
    end

    assign cfg_rdata = cfg_q;
    assign rx_rdata  = rx_q;
    assign xfer_done = done_q;
    assign sck_o     = sck_q;
    assign mosi_o    = dout;
    assign miso_o    = dout;

    // While idle, SCK settles to the configured polarity on the next clock.
    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE) |=> (sck_q == $past(cfg_q.cpol)));

    // A disabled block leaves no master transfer running.
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |=> (state_q == S_IDLE));

    // In the master role, done only rises at the end of a running transfer.
    assert_done_end_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_q) && cfg_q.master) |-> ($past(state_q) == S_XFER));

    // Select released mid-byte drops the edge count.
    assert_abort_cnt_R10: assert property (@(posedge clk) disable iff (rst)
        (is_slave && ss_end) |=> (bit_cnt == '0));

    // A transmit write during a transfer leaves the held byte alone.
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_we && state_q == S_XFER) |=> $stable(tx_hold_q));

endmodule

// File: tb/sim_spi_ctl_top.sv
module sim_spi_ctl_top;

    localparam int CLK_PERIOD = 10;
    localparam int SL_HALF    = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, tx_we;
    logic [7:0] cfg_wdata, tx_wdata;
    logic [7:0] cfg_rdata, rx_rdata;
    logic       xfer_done, sck_o, sck_i, ss_n_i, mosi_o, mosi_i, miso_o, miso_i;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_ctl_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_rdata(rx_rdata), .xfer_done(xfer_done),
        .sck_o(sck_o), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i)
    );

    typedef struct {
        bit         slave;
        logic [7:0] exp_out;
        logic [7:0] exp_rx;
        int         exp_period;
        bit         cpol;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         fails = 0;

    bit         mon_master = 0;
    bit         m_cpol, m_cpha, m_lsb;
    logic [7:0] m_miso_byte, cap_mosi, cap_miso;
    int         ecnt = 0, cyc = 0, e1_cyc = 0, e3_cyc = 0;
    logic       prev_sck = 1'b0, prev_done = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic bit_at(input logic [7:0] b, input int k, input bit lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    function automatic int sck_div(input int code);
        case (code)
            0: return 4;
            1: return 16;
            2: return 64;
            3: return 128;
            4: return 2;
            5: return 8;
            6: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor: behavioural slave partner for master runs, scoreboard pop on done.
    always begin
        @(posedge clk);
        #(CLK_PERIOD / 4);
        cyc++;
        if (!rst) begin
            if (mon_master && (sck_o !== prev_sck)) begin
                ecnt++;
                if (ecnt == 1) e1_cyc = cyc;
                if (ecnt == 3) e3_cyc = cyc;
                if (m_cpha ? (ecnt % 2 == 0) : (ecnt % 2 == 1)) begin
                    if (m_lsb) cap_mosi[(ecnt-1)/2] = mosi_o;
                    else       cap_mosi[7-(ecnt-1)/2] = mosi_o;
                end else begin
                    if (!m_cpha && (ecnt / 2) < 8)
                        miso_i = bit_at(m_miso_byte, ecnt / 2, m_lsb);
                    else if (m_cpha && ((ecnt-1) / 2) < 8)
                        miso_i = bit_at(m_miso_byte, (ecnt-1) / 2, m_lsb);
                end
            end
            prev_sck = sck_o;
            if (xfer_done && !prev_done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "done with no pending transfer", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(rx_rdata == it.exp_rx, "R5/R8", "received byte", rx_rdata, it.exp_rx);
                    if (!it.slave) begin
                        check(cap_mosi == it.exp_out, "R5/R6", "MOSI byte", cap_mosi, it.exp_out);
                        check((e3_cyc - e1_cyc) == it.exp_period, "R4", "SCK period", e3_cyc - e1_cyc, it.exp_period);
                        check(sck_o == it.cpol, "R3", "SCK at idle after done", sck_o, it.cpol);
                        check(ecnt == 16, "R3", "SCK edge count", ecnt, 16);
                    end else begin
                        check(cap_miso == it.exp_out, "R9", "MISO byte", cap_miso, it.exp_out);
                    end
                end
            end
            prev_done = xfer_done;
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] rxb, input bit rewrite);
        item_t it;
        write_cfg(cfg);
        m_cpol = cfg[4]; m_cpha = cfg[3]; m_lsb = cfg[6];
        m_miso_byte = rxb; ecnt = 0; cap_mosi = 8'h00; mon_master = 1;
        miso_i = bit_at(rxb, 0, cfg[6]);
        it.slave = 0; it.exp_out = tx; it.exp_rx = rxb; it.cpol = cfg[4];
        it.exp_period = sck_div(int'(cfg[2:0]));
        sb.push_back(it);
        tx_we = 1'b1; tx_wdata = tx;
        @(negedge clk);
        tx_we = 1'b0;
        if (!cfg[3]) check(mosi_o == bit_at(tx, 0, cfg[6]), "R7", "master first bit before first edge", mosi_o, bit_at(tx, 0, cfg[6]));
        if (rewrite) begin
            repeat (5) @(negedge clk);
            tx_we = 1'b1; tx_wdata = ~tx;
            @(negedge clk);
            tx_we = 1'b0;
        end
        wait (xfer_done);
        repeat (3) @(negedge clk);
    endtask

    task automatic slave_xfer(input logic [7:0] cfg, input logic [7:0] stx, input logic [7:0] mbyte, input int abort_bits);
        item_t it;
        bit cpha, lsb;
        cpha = cfg[3]; lsb = cfg[6];
        mon_master = 0;
        write_cfg(cfg);
        sck_i = cfg[4]; ss_n_i = 1'b1; mosi_i = 1'b0;
        @(negedge clk);
        tx_we = 1'b1; tx_wdata = stx;
        @(negedge clk);
        tx_we = 1'b0;
        repeat (4) @(negedge clk);
        if (abort_bits > 0) begin
            ss_n_i = 1'b0; mosi_i = 1'b1;
            repeat (SL_HALF) @(negedge clk);
            for (int e = 0; e < 2 * abort_bits; e++) begin
                sck_i = ~sck_i;
                repeat (SL_HALF) @(negedge clk);
            end
            ss_n_i = 1'b1;
            repeat (8) @(negedge clk);
            check(xfer_done == 1'b0, "R10", "done after aborted byte", xfer_done, 0);
        end
        it.slave = 1; it.exp_out = stx; it.exp_rx = mbyte; it.exp_period = 0; it.cpol = cfg[4];
        sb.push_back(it);
        cap_miso = 8'h00;
        ss_n_i = 1'b0;
        if (!cpha) mosi_i = bit_at(mbyte, 0, lsb);
        repeat (SL_HALF) @(negedge clk);
        if (!cpha) check(miso_o == bit_at(stx, 0, lsb), "R7", "slave first bit after select", miso_o, bit_at(stx, 0, lsb));
        for (int e = 1; e <= 16; e++) begin
            bit smp;
            smp = cpha ? (e % 2 == 0) : (e % 2 == 1);
            if (smp) begin
                if (lsb) cap_miso[(e-1)/2] = miso_o;
                else     cap_miso[7-(e-1)/2] = miso_o;
            end
            sck_i = ~sck_i;
            if (!smp) begin
                if (!cpha && (e / 2) < 8) mosi_i = bit_at(mbyte, e / 2, lsb);
                if (cpha && ((e-1) / 2) < 8) mosi_i = bit_at(mbyte, (e-1) / 2, lsb);
            end
            repeat (SL_HALF) @(negedge clk);
        end
        repeat (SL_HALF) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_wdata = 0; tx_we = 0; tx_wdata = 0;
        sck_i = 0; ss_n_i = 1; mosi_i = 0; miso_i = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_rdata == 8'h00, "R1", "config reset value", cfg_rdata, 0);
        check(xfer_done == 1'b0, "R8", "done after reset", xfer_done, 0);
        check(sck_o == 1'b0, "R3", "SCK after reset", sck_o, 0);

        write_cfg(8'h5A);
        check(cfg_rdata == 8'h5A, "R1", "config readback", cfg_rdata, 8'h5A);

        // R2: disabled master, transmit write must not start anything
        write_cfg(8'h20);
        ecnt = 0; mon_master = 1; m_cpol = 0; m_cpha = 0; m_lsb = 0;
        tx_we = 1'b1; tx_wdata = 8'hC3;
        @(negedge clk);
        tx_we = 1'b0;
        repeat (300) @(negedge clk);
        check(ecnt == 0, "R2", "SCK edges while disabled", ecnt, 0);
        check(xfer_done == 1'b0, "R2", "done while disabled", xfer_done, 0);

        // Master sweep: every mode, order and rate code
        for (int m = 0; m < 8; m++) begin
            for (int code = 0; code < 8; code++) begin
                logic [7:0] cfg;
                logic [7:0] txb, rxb;
                cfg = {1'b1, m[2], 1'b1, m[1], m[0], code[2:0]};
                txb = 8'h3C ^ 8'((m * 8 + code) * 37);
                rxb = 8'hA7 + 8'((m * 8 + code) * 11);
                master_xfer(cfg, txb, rxb, 1'b0);
            end
        end

        // R11: write during a running transfer
        master_xfer(8'hA1, 8'h96, 8'h5C, 1'b1);

        // R9: slave in every mode and order
        for (int m = 0; m < 8; m++) begin
            slave_xfer({1'b1, m[2], 1'b0, m[1], m[0], 3'b000}, 8'h71 + 8'(m * 29), 8'h1E ^ 8'(m * 53), 0);
        end

        // R10: select released after three bits, then a full byte
        slave_xfer(8'h80, 8'hB4, 8'h4D, 3);
        slave_xfer(8'hD8, 8'h2B, 8'hE6, 5);

        // R8: accepted write clears done
        check(xfer_done == 1'b1, "R8", "done held after slave byte", xfer_done, 1);
        @(negedge clk);
        tx_we = 1'b1; tx_wdata = 8'h00;
        @(negedge clk);
        tx_we = 1'b0;
        check(xfer_done == 1'b0, "R8", "done cleared by transmit write", xfer_done, 0);

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R8", "transfers left without done", sb.size(), 0);
        finish_run();
    end

endmodule